// File: doc/BRIEF.md
# Reservation Monitor for Load-Locked / Store-Conditional

This block keeps one reservation per CPU port in front of a shared memory. It lets software build atomic read-modify-write sequences out of two halves: a load-locked and a store-conditional. Nothing is ever stalled. Each CPU holds a lock bit and a reserved quadword address. Any write to that quadword by another agent clears the lock bit. A later store-conditional writes memory only if its lock bit is still set, and it tells the issuer whether it passed or failed so that software can loop and retry.

Each CPU port presents one request per cycle: a plain load, a plain store, a load-locked or a store-conditional, at longword or quadword size. Other agents, such as I/O engines, report their writes on a snoop port at quadword granularity. The responses are combinational from the request and the held reservation state: memory write enable, pass, fail and alignment fault. The reservation state changes on the next clock edge.

Each CPU slot is a two-state machine, RES_IDLE and RES_HELD. It moves from RES_IDLE to RES_HELD on an aligned load-locked (reserve). In RES_HELD an aligned load-locked keeps the state and reloads the address (re-reserve). It returns from RES_HELD to RES_IDLE on any aligned store-conditional (release) or on a conflicting write by another agent (lost). In every other case it stays where it is.

Top module: `llsc_monitor`

## Requirements
- R1: An aligned load-locked from CPU i makes lock_held[i] read 1 from the next cycle on, and its reservation covers the aligned quadword containing the address (address bits above bit 2).
- R2: Load-locked and store-conditional need address bits [1:0]=0 at longword size (cpu_quad=0) and bits [2:0]=0 at quadword size (cpu_quad=1). A misaligned one raises align_err in the same cycle, asserts neither mem_we, sc_pass nor sc_fail, and leaves the issuer's reservation as it was.
- R3: A snoop write whose quadword index equals a CPU's reserved quadword clears that CPU's lock bit on the next cycle.
- R4: A plain store by another CPU to either longword of a reserved quadword clears that reservation on the next cycle.
- R5: An aligned store-conditional with the lock bit set and a matching quadword asserts mem_we and sc_pass in the same cycle. Otherwise it asserts sc_fail with mem_we low. sc_pass and sc_fail are never both high.
- R6: Every aligned store-conditional clears the issuer's lock bit on the next cycle, whether it passed or failed.
- R7: A passing store-conditional clears the reservations of all other CPUs on the same quadword on the next cycle.
- R8: A store-conditional to a quadword other than the reserved one fails.
- R9: Within one cycle, writes are ordered snoop first, then CPUs by ascending index. A store-conditional fails if the snoop or a lower-indexed CPU writes its quadword in that cycle, so at most one store-conditional per quadword passes.
- R10: Plain stores are never held back: a valid store (op 01) asserts mem_we in the same cycle, whatever any reservation holds.
- R11: After reset all lock bits are 0, and with no requests all outputs are 0.
- R12: A CPU's own plain store does not clear its own reservation, and a new load-locked replaces the reserved address.

Op encoding on cpu_op (two bits per CPU, CPU i at bits [2i+1:2i]): 00 load, 01 store, 10 load-locked, 11 store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | NCPU | Request valid, one bit per CPU |
| cpu_op | input | 2*NCPU | Operation code per CPU |
| cpu_quad | input | NCPU | 1 = quadword size, 0 = longword |
| cpu_addr | input | NCPU*AW | Byte address per CPU |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_qaddr | input | AW-3 | Quadword index of that write |
| mem_we | output | NCPU | Memory write allowed for this CPU's request |
| sc_pass | output | NCPU | Store-conditional succeeded |
| sc_fail | output | NCPU | Store-conditional failed; software retries |
| align_err | output | NCPU | Misaligned load-locked or store-conditional |
| lock_held | output | NCPU | Per-CPU lock bit |

## Verification
The properties assume that cpu_op is meaningful only when its valid bit is set, and that every input stays stable between clock edges. The bench changes inputs only on the falling edge and clears the request fields whenever valid is low. Directed sequences cover each transition of the slot machine. A random phase then draws addresses from a few neighbouring quadwords so that same-cycle collisions, misaligned offsets and snoop conflicts occur often. Every output is compared each cycle against a behavioural model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } llsc_op_e;

    typedef enum logic {
        RES_IDLE = 1'b0,
        RES_HELD = 1'b1
    } res_state_e;

    // Natural alignment for the two legal atomic sizes.
    function automatic logic is_aligned(input logic [2:0] lo, input logic quad);
        return quad ? (lo == 3'b000) : (lo[1:0] == 2'b00);
    endfunction

endpackage

// File: rtl/llsc_slot.sv
module llsc_slot
    import llsc_pkg::*;
#(
    parameter int QW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ll_go,
    input  logic          sc_go,
    input  logic          kill,
    input  logic [QW-1:0] ll_qaddr,
    output logic          held,
    output logic [QW-1:0] res_qaddr
);

    res_state_e    state, state_nx;
    logic [QW-1:0] qaddr, qaddr_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RES_IDLE;
            qaddr <= '0;
        end else begin
            state <= state_nx;
            qaddr <= qaddr_nx;
        end
    end

    always_comb begin
        state_nx = state;
        qaddr_nx = qaddr;
        unique case (state)
            RES_IDLE: begin
                if (ll_go) begin
                    state_nx = RES_HELD;       // reserve
                    qaddr_nx = ll_qaddr;
                end
            end
            RES_HELD: begin
                if (ll_go) begin
                    qaddr_nx = ll_qaddr;       // re-reserve
                end else if (sc_go || kill) begin
                    state_nx = RES_IDLE;       // release or lost
                end
            end
            default: state_nx = RES_IDLE;
        endcase
    end

    always_comb begin
        held      = (state == RES_HELD);
        res_qaddr = qaddr;
    end

endmodule

// File: rtl/llsc_resolve.sv
module llsc_resolve
    import llsc_pkg::*;
#(
    parameter int NCPU = 3,
    parameter int AW   = 16
) (
    input  logic [NCPU-1:0]        cpu_valid,
    input  logic [2*NCPU-1:0]      cpu_op,
    input  logic [NCPU-1:0]        cpu_quad,
    input  logic [NCPU*AW-1:0]     cpu_addr,
    input  logic                   snoop_valid,
    input  logic [AW-4:0]          snoop_qaddr,
    input  logic [NCPU-1:0]        held,
    input  logic [NCPU*(AW-3)-1:0] res_qaddr,
    output logic [NCPU-1:0]        ll_go,
    output logic [NCPU-1:0]        sc_go,
    output logic [NCPU-1:0]        kill,
    output logic [NCPU-1:0]        mem_we,
    output logic [NCPU-1:0]        sc_pass,
    output logic [NCPU-1:0]        sc_fail,
    output logic [NCPU-1:0]        align_err,
    output logic [NCPU*(AW-3)-1:0] req_qaddr
);

    localparam int QW = AW - 3;

    always_comb begin
        logic [NCPU-1:0] st_v, ll_v, sc_v, ae_v, pass_v, we_v, kill_v;
        logic [QW-1:0]   qi, ri;
        logic            blocked, aligned;
        llsc_op_e        op;

        // decode and alignment
        for (int i = 0; i < NCPU; i++) begin
            op      = llsc_op_e'(cpu_op[2*i +: 2]);
            aligned = is_aligned(cpu_addr[i*AW +: 3], cpu_quad[i]);
            st_v[i] = cpu_valid[i] && (op == OP_STORE);
            ll_v[i] = cpu_valid[i] && (op == OP_LL) && aligned;
            sc_v[i] = cpu_valid[i] && (op == OP_SC) && aligned;
            ae_v[i] = cpu_valid[i] && (op == OP_LL || op == OP_SC) && !aligned;
        end

        // ordered commit: snoop first, then CPUs by ascending index
        for (int i = 0; i < NCPU; i++) begin
            qi      = cpu_addr[i*AW+3 +: QW];
            blocked = snoop_valid && (snoop_qaddr == qi);
            for (int j = 0; j < i; j++) begin
                if (we_v[j] && (cpu_addr[j*AW+3 +: QW] == qi)) blocked = 1'b1;
            end
            pass_v[i] = sc_v[i] && held[i] && (res_qaddr[i*QW +: QW] == qi) && !blocked;
            we_v[i]   = st_v[i] || pass_v[i];
        end

        // conflicting writes from other agents
        for (int i = 0; i < NCPU; i++) begin
            ri        = res_qaddr[i*QW +: QW];
            kill_v[i] = snoop_valid && (snoop_qaddr == ri);
            for (int j = 0; j < NCPU; j++) begin
                if (j != i && we_v[j] && (cpu_addr[j*AW+3 +: QW] == ri)) kill_v[i] = 1'b1;
            end
        end

        for (int i = 0; i < NCPU; i++) begin
            req_qaddr[i*QW +: QW] = cpu_addr[i*AW+3 +: QW];
        end
        ll_go     = ll_v;
        sc_go     = sc_v;
        kill      = kill_v;
        mem_we    = we_v;
        sc_pass   = pass_v;
        sc_fail   = sc_v & ~pass_v;
        align_err = ae_v;
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NCPU = 3,
    parameter int AW   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCPU-1:0]     cpu_valid,
    input  logic [2*NCPU-1:0]   cpu_op,
    input  logic [NCPU-1:0]     cpu_quad,
    input  logic [NCPU*AW-1:0]  cpu_addr,
    input  logic                snoop_valid,
    input  logic [AW-4:0]       snoop_qaddr,
    output logic [NCPU-1:0]     mem_we,
    output logic [NCPU-1:0]     sc_pass,
    output logic [NCPU-1:0]     sc_fail,
    output logic [NCPU-1:0]     align_err,
    output logic [NCPU-1:0]     lock_held
);

    localparam int QW = AW - 3;

    logic [NCPU-1:0]    ll_go, sc_go, kill, held;
    logic [NCPU*QW-1:0] res_qaddr, req_qaddr;

    llsc_resolve #(.NCPU(NCPU), .AW(AW)) u_resolve (
        .cpu_valid   (cpu_valid),
        .cpu_op      (cpu_op),
        .cpu_quad    (cpu_quad),
        .cpu_addr    (cpu_addr),
        .snoop_valid (snoop_valid),
        .snoop_qaddr (snoop_qaddr),
        .held        (held),
        .res_qaddr   (res_qaddr),
        .ll_go       (ll_go),
        .sc_go       (sc_go),
        .kill        (kill),
        .mem_we      (mem_we),
        .sc_pass     (sc_pass),
        .sc_fail     (sc_fail),
        .align_err   (align_err),
        .req_qaddr   (req_qaddr)
    );

    for (genvar g = 0; g < NCPU; g++) begin : g_slot
        llsc_slot #(.QW(QW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ll_go     (ll_go[g]),
            .sc_go     (sc_go[g]),
            .kill      (kill[g]),
            .ll_qaddr  (req_qaddr[g*QW +: QW]),
            .held      (held[g]),
            .res_qaddr (res_qaddr[g*QW +: QW])
        );
    end

    assign lock_held = held;

endmodule

// File: rtl/llsc_monitor_sva.sv
module llsc_monitor_sva #(
    parameter int NCPU = 3,
    parameter int AW   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NCPU-1:0]    cpu_valid,
    input logic [2*NCPU-1:0]  cpu_op,
    input logic [NCPU*AW-1:0] cpu_addr,
    input logic [NCPU-1:0]    mem_we,
    input logic [NCPU-1:0]    sc_pass,
    input logic [NCPU-1:0]    sc_fail,
    input logic [NCPU-1:0]    align_err,
    input logic [NCPU-1:0]    lock_held
);

    for (genvar g = 0; g < NCPU; g++) begin : g_cpu
        AST_PASS_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            sc_pass[g] |-> (lock_held[g] && mem_we[g])); // R5
        AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(sc_pass[g] && sc_fail[g])); // R5
        AST_LL_SETS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid[g] && cpu_op[2*g +: 2] == 2'b10 && !align_err[g]) |=> lock_held[g]); // R1
        AST_SC_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid[g] && cpu_op[2*g +: 2] == 2'b11 && !align_err[g]) |=> !lock_held[g]); // R6
        AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            align_err[g] |-> (!mem_we[g] && !sc_pass[g] && !sc_fail[g])); // R2
        AST_STORE_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid[g] && cpu_op[2*g +: 2] == 2'b01) |-> mem_we[g]); // R10
        for (genvar h = g + 1; h < NCPU; h++) begin : g_pair
            AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
                (sc_pass[g] && sc_pass[h]) |->
                (cpu_addr[g*AW+3 +: AW-3] != cpu_addr[h*AW+3 +: AW-3])); // R9
        end
    end

endmodule

bind llsc_monitor llsc_monitor_sva #(.NCPU(NCPU), .AW(AW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_op    (cpu_op),
    .cpu_addr  (cpu_addr),
    .mem_we    (mem_we),
    .sc_pass   (sc_pass),
    .sc_fail   (sc_fail),
    .align_err (align_err),
    .lock_held (lock_held)
);

// File: tb/llsc_monitor_test.sv
`timescale 1ns/1ps
module llsc_monitor_test;

    localparam int N  = 3;
    localparam int AW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   v = '0;
    logic [2*N-1:0] op = '0;
    logic [N-1:0]   qd = '0;
    logic [N*AW-1:0] addr = '0;
    logic           sn_v = 1'b0;
    logic [AW-4:0]  sn_q = '0;
    logic [N-1:0]   mem_we, sc_pass, sc_fail, align_err, lock_held;

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 0;
    string tag = "R11";

    // behavioural reservation model
    bit m_held[N];
    int m_res[N];
    logic [N-1:0] e_we, e_pass, e_fail, e_ae, e_lock;

    always #5 clk = ~clk;

    llsc_monitor #(.NCPU(N), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(v), .cpu_op(op), .cpu_quad(qd),
        .cpu_addr(addr), .snoop_valid(sn_v), .snoop_qaddr(sn_q),
        .mem_we(mem_we), .sc_pass(sc_pass), .sc_fail(sc_fail),
        .align_err(align_err), .lock_held(lock_held)
    );

    task automatic chk(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s act=%b exp=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic req(input int c, input int o, input bit q, input int a);
        v[c]           = 1'b1;
        op[2*c +: 2]   = o[1:0];
        qd[c]          = q;
        addr[c*AW +: AW] = a[AW-1:0];
    endtask

    task automatic snoop(input int a);
        sn_v = 1'b1;
        sn_q = a[AW-1:3];
    endtask

    // expected outputs from the current inputs and model state
    task automatic predict();
        int q[N];
        bit al[N];
        for (int i = 0; i < N; i++) begin
            int o = op[2*i +: 2];
            int a = addr[i*AW +: AW];
            q[i]  = a >> 3;
            al[i] = qd[i] ? (a % 8 == 0) : (a % 4 == 0);
            e_ae[i] = v[i] && (o >= 2) && !al[i];
            e_lock[i] = m_held[i];
        end
        for (int i = 0; i < N; i++) begin
            bit blk = sn_v && (int'(sn_q) == q[i]);
            bit is_sc = v[i] && op[2*i +: 2] == 2'b11 && al[i];
            for (int j = 0; j < i; j++) if (e_we[j] && q[j] == q[i]) blk = 1;
            e_pass[i] = is_sc && m_held[i] && m_res[i] == q[i] && !blk;
            e_fail[i] = is_sc && !e_pass[i];
            e_we[i]   = (v[i] && op[2*i +: 2] == 2'b01) || e_pass[i];
        end
    endtask

    task automatic update();
        bit nh[N];
        int nr[N];
        for (int i = 0; i < N; i++) begin
            int a = addr[i*AW +: AW];
            bit al = qd[i] ? (a % 8 == 0) : (a % 4 == 0);
            bit hit = sn_v && (int'(sn_q) == m_res[i]);
            for (int j = 0; j < N; j++)
                if (j != i && e_we[j] && (int'(addr[j*AW +: AW]) >> 3) == m_res[i]) hit = 1;
            nh[i] = m_held[i];
            nr[i] = m_res[i];
            if (v[i] && op[2*i +: 2] == 2'b10 && al) begin
                nh[i] = 1; nr[i] = a >> 3;
            end else if (v[i] && op[2*i +: 2] == 2'b11 && al) begin
                nh[i] = 0;
            end else if (m_held[i] && hit) begin
                nh[i] = 0;
            end
        end
        for (int i = 0; i < N; i++) begin
            m_held[i] = nh[i];
            m_res[i]  = nr[i];
        end
    endtask

    task automatic cyc();
        #1;
        predict();
        chk("mem_we", mem_we, e_we);
        chk("sc_pass", sc_pass, e_pass);
        chk("sc_fail", sc_fail, e_fail);
        chk("align_err", align_err, e_ae);
        chk("lock_held", lock_held, e_lock);
        @(posedge clk);
        update();
        @(negedge clk);
        v = '0; op = '0; qd = '0; addr = '0; sn_v = 1'b0; sn_q = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R11 watchdog act=running exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_held[i] = 0; m_res[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        tag = "R11"; cyc();                               // idle after reset
        tag = "R1";  req(0, 2, 1, 'h100); cyc(); cyc();   // reserve, lock visible
        tag = "R12"; req(0, 1, 0, 'h104); cyc(); cyc();   // own store keeps lock
        req(0, 2, 1, 'h200); cyc();                       // re-reserve
        tag = "R8";  req(0, 3, 1, 'h100); cyc(); cyc();   // wrong quadword fails
        tag = "R5";  req(0, 2, 1, 'h200); cyc();
        req(0, 3, 1, 'h200); cyc();                       // passes
        tag = "R6";  req(0, 3, 1, 'h200); cyc(); cyc();   // lock already gone
        tag = "R3";  req(1, 2, 0, 'h304); cyc();
        snoop('h300); cyc(); req(1, 3, 0, 'h304); cyc();
        tag = "R4";  req(2, 2, 1, 'h400); cyc();
        req(0, 1, 0, 'h404); cyc(); req(2, 3, 1, 'h400); cyc();
        tag = "R10"; req(1, 2, 1, 'h500); req(0, 1, 1, 'h500); cyc(); cyc();
        tag = "R7";  req(0, 2, 1, 'h600); req(1, 2, 0, 'h604); cyc();
        req(0, 3, 1, 'h600); cyc(); req(1, 3, 0, 'h604); cyc();
        tag = "R9";  req(0, 2, 1, 'h700); req(2, 2, 1, 'h700); cyc();
        req(0, 3, 1, 'h700); req(2, 3, 1, 'h700); cyc(); cyc();
        req(1, 2, 1, 'h800); cyc();
        req(1, 3, 1, 'h800); snoop('h800); cyc(); cyc();
        tag = "R2";  req(1, 2, 1, 'h900); cyc();
        req(1, 2, 1, 'h904); cyc();                       // misaligned quad LL
        req(1, 3, 0, 'h902); cyc();                       // misaligned long SC
        req(1, 3, 1, 'h900); cyc();                       // original still valid
        req(2, 2, 0, 'h904); cyc(); cyc();                // aligned long LL

        tag = "R9";                                       // random collisions
        for (int k = 0; k < 600; k++) begin
            for (int c = 0; c < N; c++) begin
                if ($urandom_range(1, 0) == 1) begin
                    int a = 'h1000 + $urandom_range(2, 0) * 8;
                    if ($urandom_range(4, 0) == 0) a = a + $urandom_range(7, 0);
                    else a = a + $urandom_range(1, 0) * 4;
                    req(c, $urandom_range(3, 0), $urandom_range(1, 0), a);
                end
            end
            if ($urandom_range(5, 0) == 0) snoop('h1000 + $urandom_range(2, 0) * 8);
            cyc();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule